// File: doc/BRIEF.md
# Queued SPI command sequencer

This block is a master SPI engine that works through a queue of sixteen command entries. Each entry is one byte. It sets the chip-select pattern for its transfer and picks the word length. It also turns the lead delay and the trail delay on or off, and says whether the chip selects stay asserted into the next entry. A start pulse runs entries from a start pointer to an end pointer, wrapping from 15 back to 0. When the last entry has finished, the block raises a one-cycle done pulse.

Software fills the command queue through two words on a small register bus. An address word selects an entry, and the upper byte of a data word reads or writes the selected entry. Configuration inputs supply the following:

- the programmable word length,
- the clock divisor,
- the lead and trail delay counts,
- the chip-select level used between transfers.

A transmit word is loaded when each entry is fetched. The received word is presented with a one-cycle valid strobe at the end of each transfer.

Top module: `spi_cmd_queue`

## Requirements
- R1: A bus write with `bus_sel`=0 stores `bus_wdata[3:0]` as the entry index. A bus write with `bus_sel`=1 stores `bus_wdata[15:8]` into the indexed entry. `bus_rdata` shows `{12'h000, index}` when `bus_sel`=0 and `{entry, 8'h00}` when `bus_sel`=1, so the low byte always reads zero.
- R2: A `start` pulse while idle runs entries from `start_ptr` to `end_ptr` inclusive, with the index wrapping from 15 to 0. `busy` is high from the cycle after `start` until the last entry's trail ends. In that cycle `busy` falls and `done` is high for exactly one cycle.
- R3: While an entry runs, `cs` shows bits 3..0 of its command byte, starting the cycle after the entry is fetched. While idle, `cs` follows `cfg_cs_idle` with a one-cycle lag.
- R4: Command bit 7 sets chip-select continuity. When it is 0, `cs` returns to `cfg_cs_idle` as soon as the last bit ends. When it is 1, `cs` holds the entry's pattern through the trail until the next entry's pattern is fetched. After the last entry of a run, `cs` goes to `cfg_cs_idle` in either case.
- R5: Command bit 6 selects the word length. When it is 0 the word is 8 bits. When it is 1 the length comes from `cfg_bits`: 0 means 16, 8..15 are taken as given, and 1..7 mean 8.
- R6: Command bit 4 selects the lead delay from the `cs` change to the first rising `sclk`. When it is 0 the delay is one half-period. When it is 1 it is `cfg_lead` cycles, with 0 treated as 1.
- R7: Command bit 5 selects the trail after the last bit. When it is 1 the trail is `cfg_trail` cycles, with 0 treated as 1. When it is 0 it is 1 cycle. Another entry is fetched one cycle after the trail ends.
- R8: `sclk` idles low (mode 0). Each bit is `h` cycles high followed by `h` cycles low, where `h` is `cfg_baud`, or 2 when `cfg_baud` is below 2. `mosi` carries the transmit word MSB first, holds each bit from before its rising edge, changes on the falling edge, and is 0 once all bits are sent.
- R9: `miso` is sampled on each rising `sclk`. At the end of each word, `rx_valid` is high for one cycle, and `rx_word` holds the received bits right-aligned with the first bit received as the MSB.
- R10: An `abort` while busy returns the block to idle on the next edge, with `sclk` low, `cs` at `cfg_cs_idle` and no `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_we | input | 1 | Bus write strobe |
| bus_sel | input | 1 | 0 selects the index word, 1 selects the data word |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data for the selected word |
| cfg_bits | input | 4 | Programmable word length |
| cfg_baud | input | 8 | Half-period of `sclk` in clock cycles |
| cfg_lead | input | 8 | Lead delay used when command bit 4 is set |
| cfg_trail | input | 8 | Trail delay used when command bit 5 is set |
| cfg_cs_idle | input | 4 | Chip-select level between transfers |
| start | input | 1 | Starts a run when idle |
| abort | input | 1 | Stops a run |
| start_ptr | input | 4 | First entry of the run |
| end_ptr | input | 4 | Last entry of the run |
| tx_word | input | 16 | Transmit word, right-aligned, loaded at each fetch |
| rx_word | output | 16 | Last received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` updates |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the last entry |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | 4 | Chip-select pins |

## Verification
A wrong entry pointer or a corrupted latched command shows up within a cycle of the next fetch. It appears as a wrong `cs` pattern, or as a lead, bit count or trail of the wrong length. The next `sclk` edge or the `busy` fall then lands on the wrong cycle. A delay or half-period counter that is off by one moves an `sclk` edge by a single cycle, so the per-cycle comparison of `sclk`, `cs`, `mosi`, `busy` and `done` against the behavioural model catches it at that edge. Shift-register faults show on `mosi` at the next bit, or in `rx_word` at the next `rx_valid`.

// File: rtl/spi_seq_pkg.sv
`timescale 1ns/1ps
package spi_seq_pkg;

  localparam int unsigned NCS    = 4;
  localparam int unsigned CMD_W  = 8;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned LEN_W  = $clog2(WORD_W + 1);

  // command byte: bit 7 continuity, bit 6 length select,
  // bit 5 trail enable, bit 4 lead enable, bits 3..0 chip selects
  typedef struct packed {
    logic           keep_cs;
    logic           len_sel;
    logic           trail_en;
    logic           lead_en;
    logic [NCS-1:0] sel;
  } cmd_t;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_FETCH = 3'd1,
    SQ_LEAD  = 3'd2,
    SQ_SHIFT = 3'd3,
    SQ_TRAIL = 3'd4
  } sq_state_t;

  function automatic logic [LEN_W-1:0] word_len(input cmd_t c, input logic [3:0] bits);
    logic [LEN_W-1:0] n;
    if (!c.len_sel)          n = LEN_W'(8);
    else if (bits == 4'd0)   n = LEN_W'(16);
    else if (bits < 4'd8)    n = LEN_W'(8);
    else                     n = LEN_W'(bits);
    return n;
  endfunction

endpackage

// File: rtl/spi_cmd_store.sv
`timescale 1ns/1ps
module spi_cmd_store
  import spi_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int BUS_W = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic             bus_sel,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [AW-1:0]    eng_idx,
  output cmd_t             eng_cmd
);

  logic [AW-1:0]    index_q, index_n;
  logic [CMD_W-1:0] entry_q [DEPTH];
  logic             wr_index, wr_entry;
  logic             unused_wdata;

  assign wr_index     = bus_we && !bus_sel;
  assign wr_entry     = bus_we &&  bus_sel;
  assign unused_wdata = ^bus_wdata[BUS_W-CMD_W-1:AW];

  always_comb begin
    index_n = index_q;
    if (wr_index) index_n = bus_wdata[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) index_q <= '0;
    else        index_q <= index_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) entry_q[i] <= '0;
    end else if (wr_entry) begin
      entry_q[index_q] <= bus_wdata[BUS_W-1:BUS_W-CMD_W];
    end
  end

  assign bus_rdata = bus_sel ? {entry_q[index_q], {(BUS_W-CMD_W){1'b0}}}
                             : {{(BUS_W-AW){1'b0}}, index_q};
  assign eng_cmd   = cmd_t'(entry_q[eng_idx]);

endmodule

// File: rtl/spi_seq_ctrl.sv
`timescale 1ns/1ps
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int AW    = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [AW-1:0]    start_ptr,
  input  logic [AW-1:0]    end_ptr,
  input  cmd_t             cmd_in,
  input  logic [3:0]       cfg_bits,
  input  logic [CNT_W-1:0] cfg_baud,
  input  logic [CNT_W-1:0] cfg_lead,
  input  logic [CNT_W-1:0] cfg_trail,
  input  logic [NCS-1:0]   cfg_cs_idle,
  output logic [AW-1:0]    ptr,
  output logic             load_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             word_end_o,
  output logic [LEN_W-1:0] load_len,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic [NCS-1:0]   cs
);

  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] C_TWO = CNT_W'(2);
  localparam logic [AW-1:0]    P_ONE = AW'(1);

  sq_state_t            state_q, state_n;
  logic [AW-1:0]        ptr_q, ptr_n;
  cmd_t                 cur_q, cur_n;
  logic [CNT_W-1:0]     cnt_q, cnt_n;
  logic [LEN_W-2:0]     bit_q, bit_n;
  logic                 ph_q, ph_n;
  logic                 sclk_q, sclk_n;
  logic [NCS-1:0]       cs_q, cs_n;
  logic                 done_q, done_n;

  logic [CNT_W-1:0]     half, fetch_lead, trail_len;
  logic [LEN_W-1:0]     cur_len;
  logic                 cnt_zero, last_bit;

  assign half       = (cfg_baud < C_TWO) ? C_TWO : cfg_baud;
  assign fetch_lead = !cmd_in.lead_en ? half :
                      ((cfg_lead == '0) ? C_ONE : cfg_lead);
  assign trail_len  = !cur_q.trail_en ? C_ONE :
                      ((cfg_trail == '0) ? C_ONE : cfg_trail);
  assign cur_len    = word_len(cur_q, cfg_bits);
  assign load_len   = word_len(cmd_in, cfg_bits);
  assign cnt_zero   = (cnt_q == '0);
  assign last_bit   = (bit_q == '0);

  always_comb begin
    state_n    = state_q;
    ptr_n      = ptr_q;
    cur_n      = cur_q;
    cnt_n      = cnt_q;
    bit_n      = bit_q;
    ph_n       = ph_q;
    sclk_n     = sclk_q;
    cs_n       = cs_q;
    done_n     = 1'b0;
    load_o     = 1'b0;
    rise_o     = 1'b0;
    fall_o     = 1'b0;
    word_end_o = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        cs_n   = cfg_cs_idle;
        sclk_n = 1'b0;
        if (start) begin
          ptr_n   = start_ptr;
          state_n = SQ_FETCH;
        end
      end
      SQ_FETCH: begin
        cur_n   = cmd_in;
        cs_n    = cmd_in.sel;
        cnt_n   = fetch_lead - C_ONE;
        load_o  = 1'b1;
        state_n = SQ_LEAD;
      end
      SQ_LEAD: begin
        if (!cnt_zero) begin
          cnt_n = cnt_q - C_ONE;
        end else begin
          state_n = SQ_SHIFT;
          sclk_n  = 1'b1;
          ph_n    = 1'b0;
          cnt_n   = half - C_ONE;
          bit_n   = (LEN_W-1)'(cur_len - LEN_W'(1));
          rise_o  = 1'b1;
        end
      end
      SQ_SHIFT: begin
        if (!cnt_zero) begin
          cnt_n = cnt_q - C_ONE;
        end else if (!ph_q) begin
          sclk_n = 1'b0;
          ph_n   = 1'b1;
          cnt_n  = half - C_ONE;
          fall_o = 1'b1;
        end else if (last_bit) begin
          state_n    = SQ_TRAIL;
          cnt_n      = trail_len - C_ONE;
          word_end_o = 1'b1;
          if (!cur_q.keep_cs) cs_n = cfg_cs_idle;
        end else begin
          bit_n  = bit_q - 1'b1;
          sclk_n = 1'b1;
          ph_n   = 1'b0;
          cnt_n  = half - C_ONE;
          rise_o = 1'b1;
        end
      end
      SQ_TRAIL: begin
        if (!cnt_zero) begin
          cnt_n = cnt_q - C_ONE;
        end else if (ptr_q == end_ptr) begin
          state_n = SQ_IDLE;
          cs_n    = cfg_cs_idle;
          done_n  = 1'b1;
        end else begin
          ptr_n   = ptr_q + P_ONE;
          state_n = SQ_FETCH;
        end
      end
      default: state_n = SQ_IDLE;
    endcase
    if (abort && (state_q != SQ_IDLE)) begin
      state_n    = SQ_IDLE;
      cs_n       = cfg_cs_idle;
      sclk_n     = 1'b0;
      done_n     = 1'b0;
      load_o     = 1'b0;
      rise_o     = 1'b0;
      fall_o     = 1'b0;
      word_end_o = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      ptr_q   <= '0;
      cur_q   <= '0;
      cnt_q   <= '0;
      bit_q   <= '0;
      ph_q    <= 1'b0;
      sclk_q  <= 1'b0;
      cs_q    <= '1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      ptr_q   <= ptr_n;
      cur_q   <= cur_n;
      cnt_q   <= cnt_n;
      bit_q   <= bit_n;
      ph_q    <= ph_n;
      sclk_q  <= sclk_n;
      cs_q    <= cs_n;
      done_q  <= done_n;
    end
  end

  assign ptr  = ptr_q;
  assign busy = (state_q != SQ_IDLE);
  assign done = done_q;
  assign sclk = sclk_q;
  assign cs   = cs_q;

endmodule

// File: rtl/spi_shift_unit.sv
`timescale 1ns/1ps
module spi_shift_unit
  import spi_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              rise,
  input  logic              fall,
  input  logic              word_end,
  input  logic [LEN_W-1:0]  load_len,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);

  logic [WORD_W-1:0] tx_q, tx_n;
  logic [WORD_W-1:0] rx_q, rx_n;
  logic [WORD_W-1:0] out_q, out_n;
  logic              vld_q;

  always_comb begin
    tx_n  = tx_q;
    rx_n  = rx_q;
    out_n = out_q;
    if (load) begin
      tx_n = tx_word << (LEN_W'(WORD_W) - load_len);
      rx_n = '0;
    end else begin
      if (fall) tx_n = {tx_q[WORD_W-2:0], 1'b0};
      if (rise) rx_n = {rx_q[WORD_W-2:0], miso};
    end
    if (word_end) out_n = rx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      tx_q  <= tx_n;
      rx_q  <= rx_n;
      out_q <= out_n;
      vld_q <= word_end;
    end
  end

  assign mosi     = tx_q[WORD_W-1];
  assign rx_word  = out_q;
  assign rx_valid = vld_q;

endmodule

// File: rtl/spi_cmd_queue.sv
`timescale 1ns/1ps
module spi_cmd_queue
  import spi_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_sel,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic [3:0]        cfg_bits,
  input  logic [CNT_W-1:0]  cfg_baud,
  input  logic [CNT_W-1:0]  cfg_lead,
  input  logic [CNT_W-1:0]  cfg_trail,
  input  logic [NCS-1:0]    cfg_cs_idle,
  input  logic              start,
  input  logic              abort,
  input  logic [AW-1:0]     start_ptr,
  input  logic [AW-1:0]     end_ptr,
  input  logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NCS-1:0]    cs
);

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic [AW-1:0]    eng_ptr;
  cmd_t             eng_cmd;
  logic             sh_load, sh_rise, sh_fall, sh_end;
  logic [LEN_W-1:0] sh_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  spi_cmd_store #(.DEPTH(DEPTH), .BUS_W(16)) i_store (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_we    (bus_we),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .eng_idx   (eng_ptr),
    .eng_cmd   (eng_cmd)
  );

  spi_seq_ctrl #(.AW(AW), .CNT_W(CNT_W)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .start       (start),
    .abort       (abort),
    .start_ptr   (start_ptr),
    .end_ptr     (end_ptr),
    .cmd_in      (eng_cmd),
    .cfg_bits    (cfg_bits),
    .cfg_baud    (cfg_baud),
    .cfg_lead    (cfg_lead),
    .cfg_trail   (cfg_trail),
    .cfg_cs_idle (cfg_cs_idle),
    .ptr         (eng_ptr),
    .load_o      (sh_load),
    .rise_o      (sh_rise),
    .fall_o      (sh_fall),
    .word_end_o  (sh_end),
    .load_len    (sh_len),
    .busy        (busy),
    .done        (done),
    .sclk        (sclk),
    .cs          (cs)
  );

  spi_shift_unit i_shift (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (sh_load),
    .rise     (sh_rise),
    .fall     (sh_fall),
    .word_end (sh_end),
    .load_len (sh_len),
    .tx_word  (tx_word),
    .miso     (miso),
    .mosi     (mosi),
    .rx_word  (rx_word),
    .rx_valid (rx_valid)
  );

endmodule

// File: rtl/spi_cmd_queue_chk.sv
`timescale 1ns/1ps
module spi_cmd_queue_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic [15:0] bus_rdata,
  input logic [3:0]  cfg_cs_idle,
  input logic        abort,
  input logic        busy,
  input logic        done,
  input logic        sclk,
  input logic        rx_valid,
  input logic [3:0]  cs
);

  assert_low_byte_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |-> (bus_rdata[7:0] == 8'h00));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_cs_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (cs == $past(cfg_cs_idle)));

  assert_sclk_rest_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  assert_rx_in_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> busy);

  assert_abort_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && busy) |=> (!busy && !done && !sclk));

endmodule

bind spi_cmd_queue spi_cmd_queue_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .bus_sel     (bus_sel),
  .bus_rdata   (bus_rdata),
  .cfg_cs_idle (cfg_cs_idle),
  .abort       (abort),
  .busy        (busy),
  .done        (done),
  .sclk        (sclk),
  .rx_valid    (rx_valid),
  .cs          (cs)
);

// File: tb/test_spi_cmd_queue.sv
`timescale 1ns/1ps
module test_spi_cmd_queue;

  logic        clk = 1'b0;
  logic        rst_n, bus_we, bus_sel, start, abort;
  logic [15:0] bus_wdata, bus_rdata, tx_word, rx_word;
  logic [3:0]  cfg_bits, cfg_cs_idle, start_ptr, end_ptr, cs;
  logic [7:0]  cfg_baud, cfg_lead, cfg_trail;
  logic        rx_valid, busy, done, sclk, mosi, miso;

  always #10 clk = ~clk;
  assign miso = ~mosi;

  spi_cmd_queue i_spi_cmd_queue (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_bits(cfg_bits),
    .cfg_baud(cfg_baud), .cfg_lead(cfg_lead), .cfg_trail(cfg_trail),
    .cfg_cs_idle(cfg_cs_idle), .start(start), .abort(abort),
    .start_ptr(start_ptr), .end_ptr(end_ptr), .tx_word(tx_word),
    .rx_word(rx_word), .rx_valid(rx_valid), .busy(busy), .done(done),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs(cs)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0] mref [16];

  // reference expectations, advanced by the model after each rising edge
  logic       model_on = 1'b0;
  logic       mosi_on  = 1'b0;
  logic       e_busy = 1'b0, e_done = 1'b0, e_sclk = 1'b0, e_mosi = 1'b0, e_rxv = 1'b0;
  logic [3:0] e_cs = 4'hF;
  logic [15:0] e_rxw = 16'h0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always begin
    @(negedge clk);
    #1;
    if (model_on) begin
      chk(busy === e_busy, "R2 busy", 32'(busy), 32'(e_busy));
      chk(done === e_done, "R2 done", 32'(done), 32'(e_done));
      chk(cs === e_cs, "R3 R4 cs", 32'(cs), 32'(e_cs));
      chk(sclk === e_sclk, "R6 R7 R8 sclk", 32'(sclk), 32'(e_sclk));
      chk(rx_valid === e_rxv, "R9 rx_valid", 32'(rx_valid), 32'(e_rxv));
      if (mosi_on) chk(mosi === e_mosi, "R5 R8 mosi", 32'(mosi), 32'(e_mosi));
      if (e_rxv)   chk(rx_word === e_rxw, "R5 R9 rx_word", 32'(rx_word), 32'(e_rxw));
    end
  end

  function automatic int len_of(input logic [7:0] c);
    if (!c[6]) return 8;
    if (cfg_bits == 0) return 16;
    if (cfg_bits < 8) return 8;
    return int'(cfg_bits);
  endfunction

  task automatic model(input int sp, input int ep, input logic [15:0] tx);
    int p = sp;
    int len, half, lead, trail;
    logic [7:0] c;
    @(posedge clk);
    e_busy = 1'b1;
    forever begin
      c     = mref[p];
      len   = len_of(c);
      half  = (cfg_baud < 2) ? 2 : int'(cfg_baud);
      lead  = !c[4] ? half : ((cfg_lead == 0) ? 1 : int'(cfg_lead));
      trail = !c[5] ? 1 : ((cfg_trail == 0) ? 1 : int'(cfg_trail));
      @(posedge clk);
      e_cs = c[3:0];
      e_mosi = tx[len-1];
      mosi_on = 1'b1;
      repeat (lead) @(posedge clk);
      for (int b = 0; b < len; b++) begin
        e_sclk = 1'b1;
        repeat (half) @(posedge clk);
        e_sclk = 1'b0;
        e_mosi = (b < len - 1) ? tx[len-2-b] : 1'b0;
        repeat (half) @(posedge clk);
      end
      e_rxv = 1'b1;
      e_rxw = (~tx) & 16'((32'd1 << len) - 1);
      if (!c[7]) e_cs = cfg_cs_idle;
      @(posedge clk);
      e_rxv = 1'b0;
      repeat (trail - 1) @(posedge clk);
      if (p == ep) begin
        e_busy = 1'b0;
        e_done = 1'b1;
        e_cs = cfg_cs_idle;
        mosi_on = 1'b0;
        @(posedge clk);
        e_done = 1'b0;
        break;
      end
      p = (p + 1) % 16;
    end
  endtask

  task automatic bus_wr(input logic sel, input logic [15:0] d);
    @(negedge clk);
    bus_sel = sel; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic put_cmd(input int idx, input logic [7:0] c);
    bus_wr(1'b0, 16'(idx));
    bus_wr(1'b1, {c, 8'hA5});
    mref[idx] = c;
  endtask

  task automatic set_idle(input logic [3:0] v);
    @(negedge clk);
    cfg_cs_idle = v;
    @(posedge clk);
    e_cs = v;
  endtask

  task automatic do_run(input int sp, input int ep, input logic [15:0] tx);
    @(negedge clk);
    start_ptr = 4'(sp); end_ptr = 4'(ep); tx_word = tx; start = 1'b1;
    fork
      model(sp, ep, tx);
      begin @(negedge clk); start = 1'b0; end
    join
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mref[i] = 8'h00;
    rst_n = 1'b0; bus_we = 1'b0; bus_sel = 1'b0; bus_wdata = '0;
    start = 1'b0; abort = 1'b0; start_ptr = '0; end_ptr = '0; tx_word = '0;
    cfg_bits = 4'd12; cfg_baud = 8'd3; cfg_lead = 8'd5; cfg_trail = 8'd6;
    cfg_cs_idle = 4'hF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // reset state
    chk(busy === 1'b0, "R2 reset busy", 32'(busy), 0);
    chk(done === 1'b0, "R2 reset done", 32'(done), 0);
    chk(sclk === 1'b0, "R8 reset sclk", 32'(sclk), 0);
    chk(cs === 4'hF, "R3 reset cs", 32'(cs), 32'hF);
    chk(rx_valid === 1'b0, "R9 reset rx_valid", 32'(rx_valid), 0);

    // R1 indirect command access
    put_cmd(0, 8'h0E);
    put_cmd(1, 8'hDC);
    put_cmd(2, 8'h27);
    bus_wr(1'b0, 16'hFFF1);
    @(negedge clk); bus_sel = 1'b0; #1;
    chk(bus_rdata === 16'h0001, "R1 index read", 32'(bus_rdata), 32'h0001);
    @(negedge clk); bus_sel = 1'b1; #1;
    chk(bus_rdata === 16'hDC00, "R1 entry read low byte zero", 32'(bus_rdata), 32'hDC00);
    bus_wr(1'b0, 16'h0002);
    @(negedge clk); bus_sel = 1'b1; #1;
    chk(bus_rdata === 16'h2700, "R1 entry 2 read", 32'(bus_rdata), 32'h2700);
    put_cmd(14, 8'hF3);
    put_cmd(15, 8'h08);
    put_cmd(5, 8'hC5);
    put_cmd(7, 8'h10);
    bus_wr(1'b0, 16'h0005);
    @(negedge clk); bus_sel = 1'b1; #1;
    chk(bus_rdata === 16'hC500, "R1 entry 5 read", 32'(bus_rdata), 32'hC500);

    model_on = 1'b1;
    // run A: default, programmed length with lead, trail with continuity changes
    do_run(0, 2, 16'hA5C3);

    // run B: wrap 14..1, 16-bit words, minimum divisor, zero delays
    cfg_bits = 4'd0; cfg_baud = 8'd0; cfg_lead = 8'd0; cfg_trail = 8'd0;
    set_idle(4'h0);
    do_run(14, 1, 16'h3C96);

    // run C: short programmed length taken as 8, single entry, continuity on last
    cfg_bits = 4'd5; cfg_baud = 8'd2;
    set_idle(4'hA);
    do_run(5, 5, 16'h00F0);

    // R10 abort in the lead delay
    model_on = 1'b0;
    cfg_lead = 8'd40;
    @(negedge clk);
    start_ptr = 4'd7; end_ptr = 4'd7; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    #1;
    chk(busy === 1'b1, "R10 busy before abort", 32'(busy), 1);
    chk(cs === 4'h0, "R3 cs during lead", 32'(cs), 0);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0; #1;
    chk(busy === 1'b0, "R10 busy after abort", 32'(busy), 0);
    chk(cs === 4'hA, "R10 cs after abort", 32'(cs), 32'hA);
    chk(sclk === 1'b0, "R10 sclk after abort", 32'(sclk), 0);
    for (int k = 0; k < 6; k++) begin
      chk(done === 1'b0, "R10 no done after abort", 32'(done), 0);
      @(negedge clk); #1;
    end

    // clean run after abort
    e_cs = 4'hA;
    model_on = 1'b1;
    cfg_bits = 4'd9; cfg_baud = 8'd4;
    do_run(1, 1, 16'h01B7);
    model_on = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule